// File: doc/BRIEF.md
# Repeat-Mode DMA Address Sequencer

This block produces the addresses and the transfer count for a single DMA channel that runs in a circular repeat mode. It keeps a 24-bit memory-side pointer and a fixed 8-bit peripheral-side address. It counts transfers with an 8-bit down-counter, and that counter reloads from a held starting count. Each accepted request issues one transfer, steps the memory pointer by one element, and decrements the counter. When the counter reaches zero, the counter is reloaded and the pointer goes back to where the block began. The channel then starts over. It raises no completion flag and no interrupt.

A role-select input decides which side is the source and which is the destination. The address generator does not perform the bus cycles, arbitrate between channels or generate peripheral requests. Setup writes for the pointer, the counter, the starting count and the peripheral address are accepted only while the channel is disabled.

Top module: `rpt_dma_seq`

## Requirements
- R1: After reset, the memory pointer, peripheral address, counter and starting count are all zero, and `issue` is 0.
- R2: A setup write (`wr_mem`, `wr_cnt`, `wr_init`, `wr_io`) made while `en` is 0 takes effect on the next clock edge. The same write made while `en` is 1 is ignored.
- R3: The peripheral address does not change while `en` is 1. It appears on the source or destination output zero-extended to 24 bits.
- R4: When `en` and `req` are both 1, `issue` is 1 in that cycle and the outputs show the current addresses. On the next edge the pointer moves by 1 (when `sz_word` is 0) or by 2 (when `sz_word` is 1), up when `dir_dec` is 0 and down when `dir_dec` is 1.
- R5: Each issued transfer decrements the counter by one. The transfer that brings the counter to zero reloads it from the starting count. The counter and the starting count must be loaded with the same nonzero value.
- R6: On that reload, the pointer returns to its starting value, which is the stepped address minus (±1)·(1 or 2)·starting count. Transfers then repeat with no end.
- R7: While `en` is 0, the pointer and counter hold. Setting `en` back to 1 resumes from the held state.
- R8: A `req` that arrives while `en` is 0 does not issue a transfer and is not queued.
- R9: The pointer wraps modulo 2^24 at either end of the address space.
- R10: While `sz_word` is 1, bit 0 of the memory pointer is treated as 0, both on the outputs and when stepping. `xfer_word` follows `sz_word`.
- R11: When `io_is_src` is 1, `src_addr` is the peripheral address and `dst_addr` is the memory pointer. When it is 0, the two roles swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Channel enable |
| req | input | 1 | Transfer request strobe |
| dir_dec | input | 1 | 0 = pointer steps up, 1 = steps down |
| sz_word | input | 1 | 0 = byte, 1 = word (2 bytes) |
| io_is_src | input | 1 | 1 = peripheral is the source, 0 = peripheral is the destination |
| wr_mem | input | 1 | Load the memory pointer |
| wr_mem_data | input | 24 | Memory pointer value |
| wr_cnt | input | 1 | Load the counter |
| wr_cnt_data | input | 8 | Counter value |
| wr_init | input | 1 | Load the starting count |
| wr_init_data | input | 8 | Starting count value |
| wr_io | input | 1 | Load the peripheral address |
| wr_io_data | input | 8 | Peripheral address value |
| src_addr | output | 24 | Source address of the current transfer |
| dst_addr | output | 24 | Destination address of the current transfer |
| xfer_word | output | 1 | Transfer size, 1 = word |
| issue | output | 1 | Transfer issued this cycle |

## Verification
The counter has no port, so its value can only be seen through the cycle in which the pointer rewinds. The hardest cases are the pause-and-resume path and the ignored writes. In both, a wrong counter would show only as a rewind at the wrong step. The stimulus therefore stops a block partway through and sends requests while the channel is disabled. It then resumes, or tries writes while enabled, and checks that the rewind lands on exactly the cycle the block length predicts. It also runs a block across the top and the bottom of the address space in both step directions, so that the wrap and the rewind cross the boundary together.

// File: rtl/rpt_dma_seq.sv
module rpt_dma_seq #(
  parameter int AW  = 24,
  parameter int IOW = 8,
  parameter int CW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          req,
  input  logic          dir_dec,
  input  logic          sz_word,
  input  logic          io_is_src,
  input  logic          wr_mem,
  input  logic [AW-1:0] wr_mem_data,
  input  logic          wr_cnt,
  input  logic [CW-1:0] wr_cnt_data,
  input  logic          wr_init,
  input  logic [CW-1:0] wr_init_data,
  input  logic          wr_io,
  input  logic [IOW-1:0] wr_io_data,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic          xfer_word,
  output logic          issue
);

  logic [AW-1:0]  mem_q;
  logic [IOW-1:0] io_q;
  logic [CW-1:0]  cnt_q, init_q;

  wire            fire    = en & req;
  wire [AW-1:0]   mem_eff = sz_word ? {mem_q[AW-1:1], 1'b0} : mem_q;
  wire [AW-1:0]   step    = sz_word ? AW'(2) : AW'(1);
  wire [CW-1:0]   cnt_dec = cnt_q - 1'b1;
  wire            last    = (cnt_dec == '0);
  wire [AW-1:0]   init_x  = {{(AW-CW){1'b0}}, init_q};
  wire [AW-1:0]   span    = last ? (sz_word ? (init_x << 1) : init_x) : '0;
  wire [AW-1:0]   mem_nx  = dir_dec ? (mem_eff - step + span) : (mem_eff + step - span);
  wire [AW-1:0]   io_x    = {{(AW-IOW){1'b0}}, io_q};

  assign src_addr  = io_is_src ? io_x : mem_eff;
  assign dst_addr  = io_is_src ? mem_eff : io_x;
  assign xfer_word = sz_word;
  assign issue     = fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q  <= '0;
      io_q   <= '0;
      cnt_q  <= '0;
      init_q <= '0;
    end else if (!en) begin
      if (wr_mem)  mem_q  <= wr_mem_data;
      if (wr_io)   io_q   <= wr_io_data;
      if (wr_cnt)  cnt_q  <= wr_cnt_data;
      if (wr_init) init_q <= wr_init_data;
    end else if (fire) begin
      mem_q <= mem_nx;
      cnt_q <= last ? init_q : cnt_dec;
    end
  end

  // R3: peripheral address holds while enabled
  p_io_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(io_q));

  // R5: counter decrements on a non-final transfer
  p_cnt_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cnt_q > 1) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R5: final transfer reloads the counter from the starting count
  p_cnt_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cnt_q == 1) |=> (cnt_q == $past(init_q)));

  // R7: disabled channel with no setup write holds pointer and counter
  p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_mem && !wr_cnt) |=> ($stable(mem_q) && $stable(cnt_q)));

  // R2: enabled channel without a request leaves the state alone
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !req) |=> ($stable(mem_q) && $stable(cnt_q) && $stable(init_q)));

  // R4: byte, upward, non-final transfer advances the pointer by one
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !sz_word && !dir_dec && cnt_q > 1) |=> (mem_q == $past(mem_q) + 1'b1));

  // R10: word transfers present an even memory address
  p_word_even_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sz_word |-> (io_is_src ? !dst_addr[0] : !src_addr[0]));

endmodule

// File: tb/rpt_dma_seq_tb_top.sv
module rpt_dma_seq_tb_top;
  logic clk = 0, rst_n = 0;
  logic en = 0, req = 0, dir_dec = 0, sz_word = 0, io_is_src = 1;
  logic wr_mem = 0, wr_cnt = 0, wr_init = 0, wr_io = 0;
  logic [23:0] wr_mem_data = 0;
  logic [7:0]  wr_cnt_data = 0, wr_init_data = 0, wr_io_data = 0;
  logic [23:0] src_addr, dst_addr;
  logic xfer_word, issue;
  int errs = 0, checks = 0;
  logic [23:0] io_exp = 0;

  always #2 clk = ~clk;

  rpt_dma_seq dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .req(req), .dir_dec(dir_dec),
    .sz_word(sz_word), .io_is_src(io_is_src),
    .wr_mem(wr_mem), .wr_mem_data(wr_mem_data),
    .wr_cnt(wr_cnt), .wr_cnt_data(wr_cnt_data),
    .wr_init(wr_init), .wr_init_data(wr_init_data),
    .wr_io(wr_io), .wr_io_data(wr_io_data),
    .src_addr(src_addr), .dst_addr(dst_addr), .xfer_word(xfer_word), .issue(issue));

  task automatic chk(string tag, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg(logic [23:0] m, logic [7:0] n, logic [7:0] io);
    @(negedge clk);
    en = 0; req = 0;
    wr_mem = 1; wr_mem_data = m;
    wr_cnt = 1; wr_cnt_data = n;
    wr_init = 1; wr_init_data = n;
    wr_io = 1; wr_io_data = io;
    @(negedge clk);
    wr_mem = 0; wr_cnt = 0; wr_init = 0; wr_io = 0;
    io_exp = {16'h0, io};
  endtask

  task automatic xfer(string tag, logic [23:0] mexp);
    @(negedge clk);
    req = 1;
    #1;
    chk({tag, " issue"}, {23'h0, issue}, 24'h1);
    if (io_is_src) begin
      chk({tag, " mem"}, dst_addr, mexp);
      chk({tag, " io R3 R11"}, src_addr, io_exp);
    end else begin
      chk({tag, " mem"}, src_addr, mexp);
      chk({tag, " io R3 R11"}, dst_addr, io_exp);
    end
    @(posedge clk);
    #1 req = 0;
  endtask

  task automatic t_reset;
    #1;
    chk("R1 issue", {23'h0, issue}, 24'h0);
    chk("R1 src", src_addr, 24'h0);
    chk("R1 dst", dst_addr, 24'h0);
  endtask

  task automatic t_inc_byte;
    dir_dec = 0; sz_word = 0; io_is_src = 1;
    cfg(24'h000100, 8'd3, 8'h55);
    en = 1;
    xfer("R4 inc", 24'h100); xfer("R4 inc", 24'h101); xfer("R5 last", 24'h102);
    xfer("R6 rewind", 24'h100); xfer("R6 again", 24'h101);
    xfer("R6 again", 24'h102); xfer("R6 repeat", 24'h100);
    chk("R10 size", {23'h0, xfer_word}, 24'h0);
  endtask

  task automatic t_dec_word;
    dir_dec = 1; sz_word = 1; io_is_src = 0;
    cfg(24'h000201, 8'd2, 8'hA3);
    en = 1;
    chk("R10 size", {23'h0, xfer_word}, 24'h1);
    xfer("R10 even", 24'h200); xfer("R4 dec word", 24'h1FE);
    xfer("R6 rewind word", 24'h200); xfer("R6 repeat", 24'h1FE);
  endtask

  task automatic t_freeze;
    dir_dec = 0; sz_word = 0; io_is_src = 1;
    cfg(24'h000010, 8'd4, 8'h07);
    en = 1;
    xfer("R7 pre", 24'h10); xfer("R7 pre", 24'h11);
    @(negedge clk); en = 0; req = 1;
    #1 chk("R8 no issue", {23'h0, issue}, 24'h0);
    @(negedge clk);
    #1 chk("R8 no issue", {23'h0, issue}, 24'h0);
    @(negedge clk); req = 0; en = 1;
    #1 chk("R8 not queued", {23'h0, issue}, 24'h0);
    chk("R7 held", dst_addr, 24'h12);
    xfer("R7 resume", 24'h12); xfer("R7 resume", 24'h13);
    xfer("R7 rewind", 24'h10);
  endtask

  task automatic t_locked;
    dir_dec = 0; sz_word = 0; io_is_src = 1;
    cfg(24'h000040, 8'd2, 8'h21);
    en = 1;
    @(negedge clk);
    wr_mem = 1; wr_mem_data = 24'h000999;
    wr_cnt = 1; wr_cnt_data = 8'd5;
    wr_init = 1; wr_init_data = 8'd5;
    wr_io = 1; wr_io_data = 8'hEE;
    @(negedge clk);
    wr_mem = 0; wr_cnt = 0; wr_init = 0; wr_io = 0;
    xfer("R2 locked", 24'h40); xfer("R2 locked", 24'h41);
    xfer("R2 locked rewind", 24'h40); xfer("R2 locked", 24'h41);
    xfer("R2 locked rewind", 24'h40);
  endtask

  task automatic t_wrap;
    dir_dec = 0; sz_word = 0; io_is_src = 1;
    cfg(24'hFFFFFF, 8'd2, 8'h01);
    en = 1;
    xfer("R9 top", 24'hFFFFFF); xfer("R9 wrap up", 24'h000000);
    xfer("R9 rewind", 24'hFFFFFF);
    dir_dec = 1; sz_word = 1;
    cfg(24'h000000, 8'd2, 8'h02);
    en = 1;
    xfer("R9 bottom", 24'h000000); xfer("R9 wrap down", 24'hFFFFFE);
    xfer("R9 rewind", 24'h000000);
  endtask

  initial begin
    fork
      begin
        t_reset();
        @(negedge clk); rst_n = 1;
        t_inc_byte();
        t_dec_word();
        t_freeze();
        t_locked();
        t_wrap();
      end
      begin
        repeat (20000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule